// File: doc/BRIEF.md
# Dual-Event Link Traffic Counter

This block watches a wide vector of single-cycle event strobes from a link controller and counts two of them at once. Each of the two counters picks its strobe through its own 7-bit select code. A select code of 40 routes received-message strobes and 104 routes posted-request-sent strobes, but any code from 0 to 127 is legal. Both counters may watch the same strobe.

Software drives the block through a small register port with a single-cycle write strobe and a combinational read path. One write to the control register can clear both counters and start them together. A later write can stop them and copy their values into shadow registers. Reads never see the live counters, so a multi-register read taken after a snapshot is always coherent. Each 40-bit count is presented as a 32-bit low word in its own register, plus an 8-bit upper field packed into the select register. Software rebuilds the full value as `(upper << 32) | low`.

Top module: `link_perf_mon`

## Requirements
- R1: After reset, every register (offsets 0x0, 0x4, 0x8, 0xC) reads zero.
- R2: In the select register at 0x0, bits [6:0] hold counter 0's select code and bits [14:8] hold counter 1's. Both read back as written. Writes to bits 7, 15 and [31:16] have no effect.
- R3: A counter adds exactly one in each clock cycle in which the run bit is set and the strobe `evt_i[code]` chosen by its select code is high. The two counters are independent, and both may choose the same code.
- R4: Bit 0 of the control register at 0x4 is the run bit. It holds its written value and reads back at bit 0. While it is clear, the counts hold. Setting it again without a clear resumes from the held value.
- R5: Writing bit 2 of 0x4 zeroes both counters at that clock edge, taking priority over any count in that cycle. Writing 0x5 clears the counters in the write cycle, and they count from the next cycle on.
- R6: Writing bit 1 of 0x4 copies each counter's value as of the end of that cycle into its shadow. With bit 0 clear (0x2), this takes the final count and stops. With bit 0 set (0x3), counting continues. Bits 1 and 2 act for one cycle only and read as 0.
- R7: Reads return shadow values only. A shadow does not change without a load request, even while its counter runs.
- R8: Counter 0's shadow low word reads at 0x8 and counter 1's at 0xC. The upper field sits in bits [23:16] of 0x0 for counter 0 and in bits [31:24] for counter 1.
- R9: Counts wrap to zero modulo 2^(LO_W+UP_W) instead of saturating.
- R10: Writes to 0x8 and 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT (128) | Event strobe vector, one bit per event code |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| addr_i | input | 4 | Byte offset for both write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |

## Verification
A counter that miscounts, or a select field that steers to the wrong strobe, is invisible until the next load request. It then shows up in the low word and upper field read right after that write, and the next read gives the same wrong value again. A shadow that updates when it should hold shows up at once: a read taken mid-run differs from the previous snapshot. A clear that loses its priority to a same-cycle count leaves an extra one in the first snapshot after a 0x5 write with the strobe already high. Narrowed counter widths bring the low-to-upper carry and the wrap within a few dozen cycles, so both can be checked at the ports.

// File: rtl/perf_mon_pkg.sv
`timescale 1ns/1ps
package perf_mon_pkg;
  localparam int NUM_CNT = 2;

  localparam logic [3:0] ADDR_SEL  = 4'h0;
  localparam logic [3:0] ADDR_CTRL = 4'h4;
  localparam logic [3:0] ADDR_LO0  = 4'h8;
  localparam logic [3:0] ADDR_LO1  = 4'hC;

  localparam int RUN_BIT  = 0;
  localparam int LOAD_BIT = 1;
  localparam int CLR_BIT  = 2;

  // field strides inside the select register
  localparam int SEL_STRIDE = 8;
  localparam int UP_BASE    = 16;
endpackage

// File: rtl/perf_ctrl_regs.sv
`timescale 1ns/1ps
module perf_ctrl_regs
  import perf_mon_pkg::*;
#(
  parameter int SEL_W = 7
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [3:0]                        addr_i,
  input  logic [31:0]                       wdata_i,
  output logic [NUM_CNT-1:0][SEL_W-1:0]     sel_o,
  output logic                              run_o,
  output logic                              ld_o,
  output logic                              clr_o
);
  logic sel_wr, ctrl_wr;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel_q;
  logic run_q;
  logic unused_wdata;

  assign sel_wr  = wr_en_i && (addr_i == ADDR_SEL);
  assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);

  // one-shot commands, live only in the write cycle
  assign clr_o = ctrl_wr && wdata_i[CLR_BIT];
  assign ld_o  = ctrl_wr && wdata_i[LOAD_BIT];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (ctrl_wr) run_q <= wdata_i[RUN_BIT];
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sel_q[k] <= '0;
      else if (sel_wr) sel_q[k] <= wdata_i[k*SEL_STRIDE +: SEL_W];
    end
  end

  assign sel_o = sel_q;
  assign run_o = run_q;

  // R4
  run_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_CTRL) |=> $stable(run_o));

  // R2
  sel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_SEL) |=> $stable(sel_o));
endmodule

// File: rtl/perf_event_counter.sv
`timescale 1ns/1ps
module perf_event_counter #(
  parameter int NUM_EVT = 128,
  parameter int SEL_W   = 7,
  parameter int CNT_W   = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               run_i,
  input  logic               clr_i,
  input  logic               ld_i,
  output logic [CNT_W-1:0]   shadow_o
);
  logic             hit;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, shadow_q;

  assign hit = evt_i[sel_i];

  // clear beats count; wraps naturally at 2^CNT_W
  always_comb begin
    if (clr_i)             cnt_nxt = '0;
    else if (run_i && hit) cnt_nxt = cnt_q + CNT_W'(1);
    else                   cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt;
  end

  // snapshot takes the value the counter holds after this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= '0;
    else if (ld_i) shadow_q <= cnt_nxt;
  end

  assign shadow_o = shadow_q;

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  // R4
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> cnt_q == $past(cnt_q));

  // R3
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R6
  shadow_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> shadow_q == cnt_q);

  // R7
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(shadow_q));
endmodule

// File: rtl/perf_readback.sv
`timescale 1ns/1ps
module perf_readback
  import perf_mon_pkg::*;
#(
  parameter int SEL_W = 7,
  parameter int LO_W  = 32,
  parameter int UP_W  = 8,
  localparam int CNT_W = LO_W + UP_W
) (
  input  logic [3:0]                    addr_i,
  input  logic [NUM_CNT-1:0][SEL_W-1:0] sel_i,
  input  logic                          run_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] shadow_i,
  output logic [31:0]                   rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_SEL: begin
        for (int k = 0; k < NUM_CNT; k++) begin
          rdata_o[k*SEL_STRIDE +: SEL_W]         = sel_i[k];
          rdata_o[UP_BASE + k*SEL_STRIDE +: UP_W] = shadow_i[k][CNT_W-1 -: UP_W];
        end
      end
      ADDR_CTRL: rdata_o[RUN_BIT] = run_i;
      ADDR_LO0:  rdata_o[LO_W-1:0] = shadow_i[0][LO_W-1:0];
      ADDR_LO1:  rdata_o[LO_W-1:0] = shadow_i[1][LO_W-1:0];
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/link_perf_mon.sv
`timescale 1ns/1ps
module link_perf_mon
  import perf_mon_pkg::*;
#(
  parameter int NUM_EVT = 128,
  parameter int LO_W    = 32,  // <= 32
  parameter int UP_W    = 8    // <= 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [3:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o
);
  localparam int SEL_W = $clog2(NUM_EVT);
  localparam int CNT_W = LO_W + UP_W;

  logic [NUM_CNT-1:0][SEL_W-1:0] sel;
  logic [NUM_CNT-1:0][CNT_W-1:0] shadow;
  logic run, ld, clr;

  perf_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .sel_o   (sel),
    .run_o   (run),
    .ld_o    (ld),
    .clr_o   (clr)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    perf_event_counter #(
      .NUM_EVT (NUM_EVT),
      .SEL_W   (SEL_W),
      .CNT_W   (CNT_W)
    ) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i),
      .sel_i    (sel[k]),
      .run_i    (run),
      .clr_i    (clr),
      .ld_i     (ld),
      .shadow_o (shadow[k])
    );
  end

  perf_readback #(
    .SEL_W (SEL_W),
    .LO_W  (LO_W),
    .UP_W  (UP_W)
  ) u_rd (
    .addr_i   (addr_i),
    .sel_i    (sel),
    .run_i    (run),
    .shadow_i (shadow),
    .rdata_o  (rdata_o)
  );
endmodule

// File: tb/link_perf_mon_test.sv
`timescale 1ns/1ps
module link_perf_mon_test;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [127:0] evt_i;
  logic         wr_en_i;
  logic [3:0]   addr_i;
  logic [31:0]  wdata_i;
  logic [31:0]  rdata_o, rdata_s;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  link_perf_mon uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o));

  // narrowed widths bring carry and wrap within reach
  link_perf_mon #(.LO_W(4), .UP_W(2)) uut_wrap (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_s));

  // {sel0, sel1, n0, n1}
  localparam logic [29:0] VEC [6] = '{
    {7'd40,  7'd104, 8'd10, 8'd7},
    {7'd104, 7'd40,  8'd3,  8'd12},
    {7'd0,   7'd127, 8'd5,  8'd0},
    {7'd127, 7'd0,   8'd0,  8'd9},
    {7'd64,  7'd64,  8'd6,  8'd11},
    {7'd1,   7'd2,   8'd25, 8'd25}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 4'h0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v, output logic [31:0] vs);
    addr_i = a;
    #1;
    v = rdata_o; vs = rdata_s;
    addr_i = 4'h0;
  endtask

  task automatic pulse(input int b, input int n);
    for (int c = 0; c < n; c++) begin
      evt_i[b] = 1'b1;
      @(negedge clk_i);
    end
    evt_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, vs;
    rst_ni = 1'b0; evt_i = '0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v, vs);
      chk("R1 main", v, 32'h0);
      chk("R1 narrow", vs, 32'h0);
    end

    // R2 select fields, reserved bits ignored
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v, vs);
    chk("R2 sel readback", v, 32'h0000_7F7F);
    chk("R2 sel readback narrow", vs, 32'h0000_7F7F);

    // R4 run bit readback; R6 one-shot bits read 0
    wr(4'h4, 32'h1);
    rd(4'h4, v, vs);
    chk("R4 run reads 1", v, 32'h1);
    wr(4'h4, 32'h7);
    rd(4'h4, v, vs);
    chk("R6 pulse bits read 0", v, 32'h1);
    wr(4'h4, 32'h0);
    rd(4'h4, v, vs);
    chk("R4 run cleared", v, 32'h0);

    // R10 low-word registers are read-only
    wr(4'h8, 32'hDEAD_BEEF);
    wr(4'hC, 32'h1234_5678);
    rd(4'h8, v, vs);
    chk("R10 lo0 unchanged", v, 32'h0);
    rd(4'hC, v, vs);
    chk("R10 lo1 unchanged", v, 32'h0);

    // R3 R8 table of select codes and strobe patterns
    for (int i = 0; i < 6; i++) begin
      logic [6:0] s0, s1;
      int n0, n1, nm, e0, e1;
      s0 = VEC[i][29:23]; s1 = VEC[i][22:16];
      n0 = int'(VEC[i][15:8]); n1 = int'(VEC[i][7:0]);
      nm = (n0 > n1) ? n0 : n1;
      e0 = (s0 == s1) ? nm : n0;
      e1 = (s0 == s1) ? nm : n1;
      wr(4'h0, {16'h0, 1'b0, s1, 1'b0, s0});
      wr(4'h4, 32'h5);
      for (int c = 0; c < nm; c++) begin
        evt_i = '0;
        if (c < n0) evt_i[s0] = 1'b1;
        if (c < n1) evt_i[s1] = 1'b1;
        @(negedge clk_i);
      end
      evt_i = '0;
      wr(4'h4, 32'h2);
      rd(4'h8, v, vs);
      chk("R3 R8 counter0 low", v, 32'(e0));
      rd(4'hC, v, vs);
      chk("R3 R8 counter1 low", v, 32'(e1));
      rd(4'h0, v, vs);
      chk("R2 R8 sel reg", v, {16'h0, 1'b0, s1, 1'b0, s0});
      rd(4'h4, v, vs);
      chk("R6 stopped after 0x2", v, 32'h0);
    end

    // R7 shadow stable while running; sel0=1 holds 25
    wr(4'h4, 32'h1);
    pulse(1, 5);
    rd(4'h8, v, vs);
    chk("R7 shadow holds while running", v, 32'd25);
    wr(4'h4, 32'h3);
    rd(4'h8, v, vs);
    chk("R6 load while running", v, 32'd30);
    rd(4'h4, v, vs);
    chk("R6 run kept by 0x3", v, 32'h1);

    // R4 stop holds, resume continues
    wr(4'h4, 32'h0);
    pulse(1, 4);
    wr(4'h4, 32'h2);
    rd(4'h8, v, vs);
    chk("R4 stopped count holds", v, 32'd30);
    wr(4'h4, 32'h1);
    pulse(1, 2);
    wr(4'h4, 32'h2);
    rd(4'h8, v, vs);
    chk("R4 resume without clear", v, 32'd32);

    // R5 clear wins over a same-cycle strobe
    evt_i[1] = 1'b1;
    wr(4'h4, 32'h5);
    repeat (3) @(negedge clk_i);
    wr(4'h4, 32'h2);
    evt_i = '0;
    rd(4'h8, v, vs);
    chk("R5 clear priority", v, 32'd4);
    rd(4'hC, v, vs);
    chk("R5 other counter cleared", v, 32'd0);

    // R8 R9 carry into upper field and wrap (narrow instance)
    wr(4'h0, 32'h0000_6828);
    wr(4'h4, 32'h5);
    pulse(40, 20);
    wr(4'h4, 32'h2);
    rd(4'h8, v, vs);
    chk("R8 narrow low word", vs, 32'd4);
    chk("R3 main count 20", v, 32'd20);
    rd(4'h0, v, vs);
    chk("R8 narrow upper field", vs, 32'h0001_6828);
    chk("R8 main upper zero", v, 32'h0000_6828);
    rd(4'hC, v, vs);
    chk("R3 narrow counter1 idle", vs, 32'd0);

    wr(4'h4, 32'h5);
    pulse(40, 70);
    wr(4'h4, 32'h2);
    rd(4'h8, v, vs);
    chk("R9 narrow wrapped low", vs, 32'd6);
    chk("R9 main no wrap", v, 32'd70);
    rd(4'h0, v, vs);
    chk("R9 narrow wrapped upper", vs, 32'h0000_6828);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule